// File: doc/BRIEF.md
# Clocked Programmable Pulse Delay Line

The block takes a single-bit signal, samples it on every clock and plays it back on its output some number of clocks later. A static 8-bit code picks that number: a base latency, plus a step size times the code. Both the base latency and the step size are counts of clocks and are set by parameters. The delay never shrinks when the code grows, and code 0 selects the base latency with no steps added.

The code is not registered. It drives the output tap selection directly, so changing it moves the output to a different point in the stored history on the very next clock, with no flush. An active-high force-low input clamps the output to zero one clock after it is sampled. The force-low input leaves the stored history alone, so after it is released the output carries on showing delayed data.

A monitor measures every high pulse on the input. When the pulse ends, the monitor compares its width with 16 percent of the delay currently programmed. If the pulse is narrower, it sets a sticky flag. A one-cycle clear pulse resets that flag.

Top module: `dly_line_prog`

## Requirements
- R1: With force_low low, a pulse_in value sampled at clock edge s appears on pulse_out right after edge s+D, where D = BASE_LAT + STEP_CLKS*dly_code. A high pulse of W samples comes out as a high pulse of exactly W cycles.
- R2: Code 0 gives D = BASE_LAT, and code 255 gives the full-scale delay D = BASE_LAT + 255*STEP_CLKS.
- R3: For any two codes a < b, the delay for b is never less than the delay for a.
- R4: A change of dly_code takes effect at the next clock edge, with no latching and no clearing of the history. If the history holds a 1 at the new tap, pulse_out becomes 1 at once.
- R5: If force_low is high at an edge, pulse_out is 0 after that edge, whatever the input or the history.
- R6: force_low does not alter the stored history. After it drops, pulse_out again shows the input delayed by D, as if no clamp had happened.
- R7: Asynchronous reset (rst_ni low) clears the history, pulse_out and short_flag. After reset is released, pulse_out stays 0 until sampled input has travelled the programmed delay.
- R8: When a high input pulse of W samples ends, short_flag is set at the edge that samples the low input if 100*W < 16*D, with D taken for the current code.
- R9: A pulse whose width satisfies 100*W >= 16*D leaves short_flag unchanged.
- R10: short_flag stays set until flag_clr is high at an edge, which clears it at that edge. If a short pulse ends at the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pulse_in | input | 1 | Signal to be delayed |
| dly_code | input | 8 | Delay code, used live |
| force_low | input | 1 | High clamps pulse_out to 0 |
| flag_clr | input | 1 | One-cycle pulse that clears short_flag |
| pulse_out | output | 1 | Delayed signal |
| short_flag | output | 1 | Sticky flag for an input pulse that was too short |

## Verification
A corrupted history bit stays hidden until it reaches the selected tap. It then shows up as a pulse edge moved or missing on pulse_out, exactly D clocks after the sample that should have made it. The bench therefore measures the first-high cycle and the high length for each pulse, at several codes including both ends of the range. A wrong tap calculation shows as a delay off by whole steps at the first pulse. A wrong width count or a wrong threshold shows on short_flag in the cycle after the pulse ends, and the bench probes it right at the 16 percent boundary. A clamp that reaches into the history is exposed by the first cycle after force_low drops.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int CODE_W  = 8;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  // short-pulse threshold as a ratio of the programmed delay
  localparam int SHORT_NUM = 16;
  localparam int SHORT_DEN = 100;

  function automatic int prog_delay(input int base, input int step, input int code);
    return base + step * code;
  endfunction
endpackage

// File: rtl/dly_rst_sync.sv
module dly_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/dly_history.sv
module dly_history #(
  parameter int DEPTH = 258,
  localparam int TAP_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  input  logic [TAP_W-1:0] tap_sel,
  output logic             tap_bit
);
  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) hist_d = {hist_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  always_comb begin
    tap_bit = 1'b0;
    if (int'(tap_sel) < DEPTH) tap_bit = hist_q[tap_sel];
  end
endmodule

// File: rtl/dly_width_mon.sv
module dly_width_mon #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [CNT_W-1:0] prog_dly,
  input  logic             flag_clr,
  output logic             prev_s,
  output logic             flag
);
  import dly_pkg::*;

  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic             prev_q, prev_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             pulse_end;
  logic             too_short;

  always_comb begin
    prev_d = din;
    cnt_d  = cnt_q;
    if (din) begin
      if (!prev_q)              cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
      else if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
    pulse_end = prev_q && !din;
    too_short = (longint'(cnt_q) * SHORT_DEN) < (longint'(prog_dly) * SHORT_NUM);
    flag_d = flag_q;
    if (flag_clr)               flag_d = 1'b0;
    if (pulse_end && too_short) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign prev_s = prev_q;
  assign flag   = flag_q;
endmodule

// File: rtl/dly_line_prog.sv
module dly_line_prog #(
  parameter int BASE_LAT    = 2,
  parameter int STEP_CLKS   = 1,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W = dly_pkg::CODE_W,
  localparam int DLY_MAX = dly_pkg::prog_delay(BASE_LAT, STEP_CLKS, dly_pkg::CODE_MAX),
  localparam int DEPTH  = DLY_MAX + 1,
  localparam int TAP_W  = $clog2(DEPTH),
  localparam int DLY_W  = $clog2(DLY_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              pulse_in,
  input  logic [CODE_W-1:0] dly_code,
  input  logic              force_low,
  input  logic              flag_clr,
  output logic              pulse_out,
  output logic              short_flag
);
  import dly_pkg::*;

  logic             rst_sync_n;
  logic [DLY_W-1:0] prog_dly;
  logic [TAP_W-1:0] tap_sel;
  logic             tap_bit;
  logic             prev_sample;
  logic             out_q, out_d;

  dly_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_ni(rst_ni), .rst_no(rst_sync_n)
  );

  // live code: no register between dly_code and the tap
  always_comb begin
    prog_dly = DLY_W'(prog_delay(BASE_LAT, STEP_CLKS, int'(dly_code)));
    // output flop adds one clock, so the tap sits one position earlier
    tap_sel  = TAP_W'(int'(prog_dly) - 1);
  end

  dly_history #(.DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_sync_n), .shift_en(1'b1), .din(pulse_in),
    .tap_sel(tap_sel), .tap_bit(tap_bit)
  );

  dly_width_mon #(.CNT_W(DLY_W)) u_mon (
    .clk(clk), .rst_n(rst_sync_n), .din(pulse_in), .prog_dly(prog_dly),
    .flag_clr(flag_clr), .prev_s(prev_sample), .flag(short_flag)
  );

  always_comb out_d = force_low ? 1'b0 : tap_bit;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_q <= 1'b0;
    else             out_q <= out_d;
  end

  assign pulse_out = out_q;
endmodule

// File: rtl/dly_line_chk.sv
module dly_line_chk #(
  parameter int BASE_LAT = 2
) (
  input logic clk,
  input logic rst_n,
  input logic din,
  input logic hold_low,
  input logic flag_clr,
  input logic dout,
  input logic short_flag,
  input logic prev_s
);
  localparam int CW = $clog2(BASE_LAT + 2) + 1;
  logic [CW-1:0] since_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst_q <= '0;
    else if (int'(since_rst_q) < BASE_LAT) since_rst_q <= since_rst_q + 1'b1;
  end

  assert_quiet_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(since_rst_q) < BASE_LAT) |-> !dout);

  assert_clamp_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_low) |-> !dout);

  assert_flag_on_pulse_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_flag) |-> ($past(prev_s) && !$past(din)));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(short_flag) && !$past(flag_clr)) |-> short_flag);

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_clr) && !($past(prev_s) && !$past(din))) |-> !short_flag);
endmodule

bind dly_line_prog dly_line_chk #(.BASE_LAT(BASE_LAT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .din(pulse_in), .hold_low(force_low),
  .flag_clr(flag_clr), .dout(pulse_out), .short_flag(short_flag),
  .prev_s(prev_sample)
);

// File: tb/tb_dly_line_prog.sv
module tb_dly_line_prog;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 3;
  localparam int STEP = 2;
  localparam int FULL = BASE + STEP * 255;

  logic clk, rst_ni, pulse_in, force_low, flag_clr;
  logic [7:0] dly_code;
  logic pulse_out, short_flag;
  int n_chk = 0, n_bad = 0;

  dly_line_prog #(.BASE_LAT(BASE), .STEP_CLKS(STEP)) dut (
    .clk(clk), .rst_ni(rst_ni), .pulse_in(pulse_in), .dly_code(dly_code),
    .force_low(force_low), .flag_clr(flag_clr),
    .pulse_out(pulse_out), .short_flag(short_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic flush();
    pulse_in = 1'b0;
    repeat (FULL + 4) @(negedge clk);
  endtask

  // sends a W-sample pulse; returns the first negedge index with output high and the high count
  task automatic run_pulse(input int code, input int w, output int first, output int highs);
    dly_code = 8'(code);
    flush();
    pulse_in = 1'b1;
    first = -1; highs = 0;
    for (int m = 1; m <= BASE + STEP*code + w + 4; m++) begin
      @(negedge clk);
      if (pulse_out) begin
        if (first < 0) first = m;
        highs++;
      end
      if (m == w) pulse_in = 1'b0;
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; pulse_in = 1'b1; dly_code = 8'd0; force_low = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 out in reset", int'(pulse_out), 0);
    check("R7 flag in reset", int'(short_flag), 0);
    pulse_in = 1'b0;
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 out after reset", int'(pulse_out), 0);
  endtask

  task automatic t_delays();
    int f, h, prev_d;
    run_pulse(0, 5, f, h);
    check("R2 code0 delay", f - 1, BASE);
    check("R1 code0 width", h, 5);
    run_pulse(255, 7, f, h);
    check("R2 code255 delay", f - 1, FULL);
    check("R1 code255 width", h, 7);
    prev_d = -1;
    for (int c = 1; c < 200; c += 49) begin
      run_pulse(c, 4, f, h);
      check("R1 delay", f - 1, BASE + STEP*c);
      check("R3 monotonic", int'(f - 1 >= prev_d), 1);
      prev_d = f - 1;
    end
  endtask

  task automatic t_clamp();
    // code 5: D = 13, pulse 20 wide is high on negedges 14..33
    dly_code = 8'd5;
    flush();
    pulse_in = 1'b1;
    for (int m = 1; m <= 36; m++) begin
      @(negedge clk);
      if (m == 15) check("R1 high before clamp", int'(pulse_out), 1);
      if (m == 17) check("R5 clamped low", int'(pulse_out), 0);
      if (m == 19) check("R6 resumes after clamp", int'(pulse_out), 1);
      if (m == 33) check("R6 history intact end", int'(pulse_out), 1);
      if (m == 34) check("R6 falls on time", int'(pulse_out), 0);
      if (m == 16) force_low = 1'b1;
      if (m == 18) force_low = 1'b0;
      if (m == 20) pulse_in = 1'b0;
    end
  endtask

  task automatic t_live_code();
    dly_code = 8'd0;
    pulse_in = 1'b1;
    repeat (FULL + 4) @(negedge clk);
    pulse_in = 1'b0;
    repeat (10) @(negedge clk);
    check("R4 short tap low", int'(pulse_out), 0);
    dly_code = 8'd255;
    @(negedge clk);
    check("R4 long tap high at once", int'(pulse_out), 1);
    dly_code = 8'd0;
    @(negedge clk);
    check("R4 back to short tap", int'(pulse_out), 0);
  endtask

  task automatic send(input int w);
    pulse_in = 1'b1;
    repeat (w) @(negedge clk);
    pulse_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_flag();
    // code 100: D = 203, threshold 100*W < 3248 -> W <= 32 is short
    pulse_in = 1'b0;
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; @(negedge clk);
    dly_code = 8'd0;
    send(1);
    check("R9 width1 at D=3 not short", int'(short_flag), 0);
    dly_code = 8'd100;
    send(33);
    check("R9 width33 not short", int'(short_flag), 0);
    send(32);
    check("R8 width32 short", int'(short_flag), 1);
    send(100);
    repeat (3) @(negedge clk);
    check("R10 sticky", int'(short_flag), 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R10 cleared", int'(short_flag), 0);
    // set wins over clear at the same edge
    pulse_in = 1'b1; repeat (5) @(negedge clk);
    pulse_in = 1'b0; flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R10 set wins", int'(short_flag), 1);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_delays();
    t_clamp();
    t_live_code();
    t_flag();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule